// File: doc/BRIEF.md
# Egress Multicast Queue Pair with Age-Ordered Merge

This block sits on the transmit side of one switch port. It holds multicast frame descriptors in two real FIFOs. The high class FIFO holds 32 entries and the low class FIFO holds 64. Each descriptor carries a buffer index and a wrapping arrival timestamp.

An incoming descriptor brings a 3-bit transmit priority. The block drops the two low bits of that priority, and the remaining bit picks the FIFO. A descriptor is refused when the target FIFO has reached its programmable threshold or is full. The refusal is reported on a drop strobe, so the frame's release tracker knows this port will never read the frame. Other destinations of the same frame are not affected.

Unicast descriptors for the same port live in an external linked-list store. That store shows this block only a head-valid flag and a head timestamp per class, and it takes a pop strobe back. Within each class, the multicast FIFO head and the unicast head behave as one logical queue, and the older of the two is offered first. Between classes, the high class is always served before the low class.

Top module: `mcq_egress_port`

## Requirements
- R1: After reset both FIFOs report zero occupancy, `tx_valid` is low while no unicast head is valid, and no enqueue is accepted while `enq_valid` is low.
- R2: Priorities 4 to 7 (bit 2 set) go to the high FIFO; priorities 0 to 3 go to the low FIFO.
- R3: Each FIFO returns its accepted descriptors in arrival order, and `tx_idx` equals the stored buffer index.
- R4: The high FIFO never holds more than 32 entries and the low FIFO never more than 64. An enqueue to a full FIFO is refused whatever its threshold.
- R5: An enqueue is refused when the target FIFO's occupancy is at or above its threshold. The refusal raises `enq_drop` in the same cycle, keeps `enq_accept` low, and leaves the occupancy unchanged.
- R6: Within one class, the multicast head is chosen (`tx_is_mc`=1) only when the unicast head is absent or the multicast timestamp is older. "Older" means that (unicast_ts − multicast_ts) mod 2^TS_W is nonzero and below 2^(TS_W−1).
- R7: When both heads of a class carry equal timestamps, the unicast head is chosen.
- R8: Whenever a high-class head is present (either source), `tx_class`=1 and no low-class source is popped.
- R9: A pop reaches at most one source per cycle, and only when `tx_ready` and `tx_valid` are both high. A unicast pop appears on `uc_pop_hi` or `uc_pop_lo` for the served class.
- R10: An accepted enqueue in the same cycle as a multicast pop of the same FIFO leaves that FIFO's occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_hi | input | CNT_W | Admission threshold for the high FIFO |
| thr_lo | input | CNT_W | Admission threshold for the low FIFO |
| enq_valid | input | 1 | Descriptor offered for enqueue |
| enq_prio | input | PRIO_W | Transmit priority of the offered descriptor |
| enq_idx | input | IDX_W | Buffer index of the offered descriptor |
| enq_ts | input | TS_W | Arrival timestamp of the offered descriptor |
| enq_accept | output | 1 | Descriptor stored this cycle |
| enq_drop | output | 1 | Descriptor refused at this port (selective drop) |
| uc_hi_valid | input | 1 | External unicast high-class head present |
| uc_hi_ts | input | TS_W | Timestamp of the unicast high-class head |
| uc_lo_valid | input | 1 | External unicast low-class head present |
| uc_lo_ts | input | TS_W | Timestamp of the unicast low-class head |
| uc_pop_hi | output | 1 | Pop strobe to the unicast high-class list |
| uc_pop_lo | output | 1 | Pop strobe to the unicast low-class list |
| tx_ready | input | 1 | Transmitter takes the offered head this cycle |
| tx_valid | output | 1 | A head is offered |
| tx_is_mc | output | 1 | Offered head comes from a multicast FIFO |
| tx_class | output | 1 | Class of the offered head (1 = high) |
| tx_idx | output | IDX_W | Buffer index of the offered multicast head (0 for unicast) |
| tx_ts | output | TS_W | Timestamp of the offered head |
| occ_hi | output | CNT_W | High FIFO occupancy |
| occ_lo | output | CNT_W | Low FIFO occupancy |

## Verification
The assertions assume the external unicast store is well behaved. A head flag may drop only after its pop, and its timestamp stays put while it waits. They also assume thresholds do not move in the cycle an enqueue is checked. The stimulus drives every input at the falling edge and changes thresholds only while `enq_valid` is low. It raises a unicast head only for the sweep that needs it and lowers it before draining the multicast FIFOs. It also keeps every timestamp gap it relies on within the half-range window where age comparison is meaningful, except where the sweep deliberately probes the wrap boundary.

// File: rtl/mcq_pkg.sv
package mcq_pkg;
  // Class code: bit left after discarding the low priority bits
  typedef enum logic {
    CLS_LO = 1'b0,
    CLS_HI = 1'b1
  } cls_e;

  localparam int NUM_CLS = 2;
endpackage

// File: rtl/mcq_fifo.sv
module mcq_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 18,
  parameter int CNT_W = 7,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mcq_admit.sv
module mcq_admit
  import mcq_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int FOLD   = 2,
  parameter int CNT_W  = 7
) (
  input  logic              enq_valid,
  input  logic [PRIO_W-1:0] enq_prio,
  input  logic [CNT_W-1:0]  thr_hi,
  input  logic [CNT_W-1:0]  thr_lo,
  input  logic [CNT_W-1:0]  occ_hi,
  input  logic [CNT_W-1:0]  occ_lo,
  input  logic              full_hi,
  input  logic              full_lo,
  output cls_e              enq_cls,
  output logic              push_hi,
  output logic              push_lo,
  output logic              accept,
  output logic              drop
);
  // Fold a transmit priority onto a queue class by shifting out low bits
  function automatic cls_e fold_prio(input logic [PRIO_W-1:0] p);
    logic [PRIO_W-1:0] s;
    s = p >> FOLD;
    return cls_e'(s[0]);
  endfunction

  function automatic logic room(input logic [CNT_W-1:0] occ,
                                input logic [CNT_W-1:0] thr,
                                input logic             is_full);
    return !is_full && (occ < thr);
  endfunction

  logic room_sel;

  always_comb begin
    enq_cls  = fold_prio(enq_prio);
    room_sel = (enq_cls == CLS_HI) ? room(occ_hi, thr_hi, full_hi)
                                   : room(occ_lo, thr_lo, full_lo);
    accept   = enq_valid && room_sel;
    drop     = enq_valid && !room_sel;
    push_hi  = accept && (enq_cls == CLS_HI);
    push_lo  = accept && (enq_cls == CLS_LO);
  end
endmodule

// File: rtl/mcq_merge.sv
module mcq_merge
  import mcq_pkg::*;
#(
  parameter int TS_W = 8
) (
  input  logic [NUM_CLS-1:0] mc_valid,
  input  logic [TS_W-1:0]    mc_ts [NUM_CLS],
  input  logic [NUM_CLS-1:0] uc_valid,
  input  logic [TS_W-1:0]    uc_ts [NUM_CLS],
  input  logic               tx_ready,
  output logic               tx_valid,
  output cls_e               tx_class,
  output logic               tx_is_mc,
  output logic [NUM_CLS-1:0] mc_pop,
  output logic [NUM_CLS-1:0] uc_pop
);
  // a is strictly older than b when b-a (mod 2^TS_W) lies in the lower half-range
  function automatic logic ts_older(input logic [TS_W-1:0] a,
                                    input logic [TS_W-1:0] b);
    logic [TS_W-1:0] d;
    d = b - a;
    return (d != '0) && !d[TS_W-1];
  endfunction

  logic [NUM_CLS-1:0] mc_win, cls_valid;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    assign mc_win[c]    = mc_valid[c] && (!uc_valid[c] || ts_older(mc_ts[c], uc_ts[c]));
    assign cls_valid[c] = mc_valid[c] || uc_valid[c];
  end

  logic fire;

  always_comb begin
    tx_valid = |cls_valid;
    tx_class = cls_valid[CLS_HI] ? CLS_HI : CLS_LO;
    tx_is_mc = mc_win[tx_class];
    fire     = tx_ready && tx_valid;
    mc_pop   = '0;
    uc_pop   = '0;
    if (fire) begin
      if (mc_win[tx_class]) mc_pop[tx_class] = 1'b1;
      else                  uc_pop[tx_class] = 1'b1;
    end
  end
endmodule

// File: rtl/mcq_egress_port.sv
module mcq_egress_port
  import mcq_pkg::*;
#(
  parameter int HI_DEPTH = 32,
  parameter int LO_DEPTH = 64,
  parameter int PRIO_W   = 3,
  parameter int FOLD     = 2,
  parameter int IDX_W    = 10,
  parameter int TS_W     = 8,
  localparam int MAXD    = (HI_DEPTH > LO_DEPTH) ? HI_DEPTH : LO_DEPTH,
  localparam int CNT_W   = $clog2(MAXD + 1),
  localparam int ENT_W   = IDX_W + TS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  thr_hi,
  input  logic [CNT_W-1:0]  thr_lo,
  input  logic              enq_valid,
  input  logic [PRIO_W-1:0] enq_prio,
  input  logic [IDX_W-1:0]  enq_idx,
  input  logic [TS_W-1:0]   enq_ts,
  output logic              enq_accept,
  output logic              enq_drop,
  input  logic              uc_hi_valid,
  input  logic [TS_W-1:0]   uc_hi_ts,
  input  logic              uc_lo_valid,
  input  logic [TS_W-1:0]   uc_lo_ts,
  output logic              uc_pop_hi,
  output logic              uc_pop_lo,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic              tx_is_mc,
  output logic              tx_class,
  output logic [IDX_W-1:0]  tx_idx,
  output logic [TS_W-1:0]   tx_ts,
  output logic [CNT_W-1:0]  occ_hi,
  output logic [CNT_W-1:0]  occ_lo
);
  // Named internal events, visible to the bound checker
  cls_e               enq_cls;
  logic [NUM_CLS-1:0] push, mc_pop, uc_pop, full, empty;
  logic [CNT_W-1:0]   occ [NUM_CLS];
  logic [ENT_W-1:0]   head [NUM_CLS];
  logic [TS_W-1:0]    mc_ts [NUM_CLS];
  logic [TS_W-1:0]    uc_ts [NUM_CLS];
  cls_e               sel_cls;
  logic               hi_present;

  mcq_admit #(.PRIO_W(PRIO_W), .FOLD(FOLD), .CNT_W(CNT_W)) u_admit (
    .enq_valid (enq_valid),
    .enq_prio  (enq_prio),
    .thr_hi    (thr_hi),
    .thr_lo    (thr_lo),
    .occ_hi    (occ[CLS_HI]),
    .occ_lo    (occ[CLS_LO]),
    .full_hi   (full[CLS_HI]),
    .full_lo   (full[CLS_LO]),
    .enq_cls   (enq_cls),
    .push_hi   (push[CLS_HI]),
    .push_lo   (push[CLS_LO]),
    .accept    (enq_accept),
    .drop      (enq_drop)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_q
    localparam int D = (c == int'(CLS_HI)) ? HI_DEPTH : LO_DEPTH;
    mcq_fifo #(.DEPTH(D), .W(ENT_W), .CNT_W(CNT_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push[c]),
      .pop   (mc_pop[c]),
      .din   ({enq_idx, enq_ts}),
      .dout  (head[c]),
      .count (occ[c]),
      .full  (full[c]),
      .empty (empty[c])
    );
    assign mc_ts[c] = head[c][TS_W-1:0];
  end

  assign uc_ts[CLS_HI] = uc_hi_ts;
  assign uc_ts[CLS_LO] = uc_lo_ts;

  mcq_merge #(.TS_W(TS_W)) u_merge (
    .mc_valid (~empty),
    .mc_ts    (mc_ts),
    .uc_valid ({uc_hi_valid, uc_lo_valid}),
    .uc_ts    (uc_ts),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_class (sel_cls),
    .tx_is_mc (tx_is_mc),
    .mc_pop   (mc_pop),
    .uc_pop   (uc_pop)
  );

  assign hi_present = !empty[CLS_HI] || uc_hi_valid;
  assign tx_class   = sel_cls;
  assign tx_idx     = tx_is_mc ? head[sel_cls][ENT_W-1:TS_W] : '0;
  assign tx_ts      = tx_is_mc ? mc_ts[sel_cls] : uc_ts[sel_cls];
  assign uc_pop_hi  = uc_pop[CLS_HI];
  assign uc_pop_lo  = uc_pop[CLS_LO];
  assign occ_hi     = occ[CLS_HI];
  assign occ_lo     = occ[CLS_LO];
endmodule

// File: rtl/mcq_checker.sv
module mcq_checker #(
  parameter int HI_DEPTH = 32,
  parameter int LO_DEPTH = 64,
  parameter int CNT_W    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enq_accept,
  input logic             enq_drop,
  input logic             enq_cls,
  input logic [1:0]       mc_pop,
  input logic [1:0]       uc_pop,
  input logic             tx_ready,
  input logic             tx_valid,
  input logic             hi_present,
  input logic [CNT_W-1:0] occ_hi,
  input logic [CNT_W-1:0] occ_lo
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_hi <= CNT_W'(HI_DEPTH)) && (occ_lo <= CNT_W'(LO_DEPTH))); // R4

  AST_DROP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(enq_accept && enq_drop)); // R5

  AST_DROP_HOLDS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_drop && enq_cls && !mc_pop[1]) |=> $stable(occ_hi)); // R5

  AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mc_pop, uc_pop})); // R9

  AST_POP_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (|{mc_pop, uc_pop}) |-> (tx_ready && tx_valid)); // R9

  AST_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    hi_present |-> !(mc_pop[0] || uc_pop[0])); // R8

  AST_BALANCE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_accept && !enq_cls && mc_pop[0]) |=> $stable(occ_lo)); // R10
endmodule

bind mcq_egress_port mcq_checker #(
  .HI_DEPTH (HI_DEPTH),
  .LO_DEPTH (LO_DEPTH),
  .CNT_W    (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enq_accept (enq_accept),
  .enq_drop   (enq_drop),
  .enq_cls    (enq_cls),
  .mc_pop     (mc_pop),
  .uc_pop     (uc_pop),
  .tx_ready   (tx_ready),
  .tx_valid   (tx_valid),
  .hi_present (hi_present),
  .occ_hi     (occ_hi),
  .occ_lo     (occ_lo)
);

// File: tb/mcq_egress_port_bench.sv
`timescale 1ns/1ps
module mcq_egress_port_bench;
  localparam int IDX_W = 10;
  localparam int TS_W  = 8;
  localparam int CNT_W = 7;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] thr_hi, thr_lo;
  logic             enq_valid;
  logic [2:0]       enq_prio;
  logic [IDX_W-1:0] enq_idx;
  logic [TS_W-1:0]  enq_ts;
  logic             enq_accept, enq_drop;
  logic             uc_hi_valid, uc_lo_valid;
  logic [TS_W-1:0]  uc_hi_ts, uc_lo_ts;
  logic             uc_pop_hi, uc_pop_lo;
  logic             tx_ready, tx_valid, tx_is_mc, tx_class;
  logic [IDX_W-1:0] tx_idx;
  logic [TS_W-1:0]  tx_ts;
  logic [CNT_W-1:0] occ_hi, occ_lo;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  mcq_egress_port u_mcq_egress_port (
    .clk(clk), .rst_n(rst_n), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .enq_valid(enq_valid), .enq_prio(enq_prio), .enq_idx(enq_idx), .enq_ts(enq_ts),
    .enq_accept(enq_accept), .enq_drop(enq_drop),
    .uc_hi_valid(uc_hi_valid), .uc_hi_ts(uc_hi_ts),
    .uc_lo_valid(uc_lo_valid), .uc_lo_ts(uc_lo_ts),
    .uc_pop_hi(uc_pop_hi), .uc_pop_lo(uc_pop_lo),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_is_mc(tx_is_mc),
    .tx_class(tx_class), .tx_idx(tx_idx), .tx_ts(tx_ts),
    .occ_hi(occ_hi), .occ_lo(occ_lo)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic enq(input int prio, input int idx, input int ts, output bit acc, output bit drp);
    enq_valid = 1'b1;
    enq_prio  = 3'(prio);
    enq_idx   = IDX_W'(idx);
    enq_ts    = TS_W'(ts);
    #1;
    acc = enq_accept;
    drp = enq_drop;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic pop(output bit mc, output bit cls, output int idx, output bit uph, output bit upl);
    tx_ready = 1'b1;
    #1;
    mc  = tx_is_mc;
    cls = tx_class;
    idx = int'(tx_idx);
    uph = uc_pop_hi;
    upl = uc_pop_lo;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a, d, mc, cls, uph, upl;
    int idx, n_acc, n_drp;
    rst_n = 1'b0; thr_hi = '1; thr_lo = '1;
    enq_valid = 0; enq_prio = 0; enq_idx = 0; enq_ts = 0;
    uc_hi_valid = 0; uc_lo_valid = 0; uc_hi_ts = 0; uc_lo_ts = 0; tx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 occ_hi", int'(occ_hi), 0);
    chk("R1 occ_lo", int'(occ_lo), 0);
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 accept idle", int'(enq_accept), 0);

    // R2 priority fold sweep: every priority once
    for (int p = 0; p < 8; p++) begin
      enq(p, 100 + p, p, a, d);
      chk("R2 accept", int'(a), 1);
    end
    chk("R2 occ_hi", int'(occ_hi), 4);
    chk("R2 occ_lo", int'(occ_lo), 4);
    // Drain: high class first (R8), arrival order within class (R3)
    for (int k = 0; k < 8; k++) begin
      int exp_idx;
      exp_idx = (k < 4) ? 104 + k : 100 + (k - 4);
      pop(mc, cls, idx, uph, upl);
      chk("R3 order idx", idx, exp_idx);
      chk("R8 class", int'(cls), (k < 4) ? 1 : 0);
      chk("R6 mc only", int'(mc), 1);
    end

    // R4 capacity with thresholds out of the way
    n_acc = 0;
    for (int k = 0; k < 40; k++) begin
      enq(6, k, 0, a, d);
      n_acc += int'(a);
    end
    chk("R4 hi accepted", n_acc, 32);
    chk("R4 hi occ", int'(occ_hi), 32);
    for (int k = 0; k < 32; k++) begin
      pop(mc, cls, idx, uph, upl);
      chk("R3 hi fifo idx", idx, k);
    end
    n_acc = 0;
    for (int k = 0; k < 70; k++) begin
      enq(2, 500 + k, 0, a, d);
      n_acc += int'(a);
    end
    chk("R4 lo accepted", n_acc, 64);
    chk("R4 lo occ", int'(occ_lo), 64);
    for (int k = 0; k < 64; k++) begin
      pop(mc, cls, idx, uph, upl);
      chk("R3 lo fifo idx", idx, 500 + k);
    end

    // R5 threshold sweep on both FIFOs
    for (int t = 0; t < 7; t++) begin
      thr_hi = CNT_W'(t);
      thr_lo = CNT_W'(t + 1);
      n_acc = 0; n_drp = 0;
      for (int k = 0; k < 8; k++) begin
        enq(7, k, 0, a, d);
        n_acc += int'(a); n_drp += int'(d);
        enq(1, k, 0, a, d);
        n_acc += int'(a); n_drp += int'(d);
      end
      chk("R5 accepted", n_acc, t + t + 1);
      chk("R5 drops", n_drp, 16 - (t + t + 1));
      chk("R5 occ_hi", int'(occ_hi), t);
      chk("R5 occ_lo", int'(occ_lo), t + 1);
      thr_hi = '1; thr_lo = '1;
      while (tx_valid) pop(mc, cls, idx, uph, upl);
    end

    // R6 / R7 exhaustive age comparison over all unicast timestamps
    for (int s = 0; s < 3; s++) begin
      int mt;
      mt = (s == 0) ? 0 : (s == 1) ? 77 : 200;
      enq(0, 9, mt, a, d);
      uc_lo_valid = 1'b1;
      for (int u = 0; u < 256; u++) begin
        bit exp_mc;
        uc_lo_ts = TS_W'(u);
        #1;
        exp_mc = $signed(TS_W'(u - mt)) > 0;
        if (u == mt) chk("R7 tie to unicast", int'(tx_is_mc), 0);
        else         chk("R6 older first", int'(tx_is_mc), int'(exp_mc));
      end
      uc_lo_valid = 1'b0;
      @(negedge clk);
      pop(mc, cls, idx, uph, upl);
    end

    // R8 / R9: low multicast older, high unicast present
    enq(3, 33, 0, a, d);
    uc_hi_valid = 1'b1; uc_hi_ts = 8'd100;
    #1;
    chk("R8 hi class offered", int'(tx_class), 1);
    chk("R9 no pop without ready", int'(uc_pop_hi), 0);
    @(negedge clk);
    chk("R9 occ_lo kept", int'(occ_lo), 1);
    pop(mc, cls, idx, uph, upl);
    chk("R9 unicast hi popped", int'(uph), 1);
    chk("R9 no lo pop", int'(upl), 0);
    chk("R8 class of pop", int'(cls), 1);
    chk("R8 lo untouched", int'(occ_lo), 1);
    uc_hi_valid = 1'b0;

    // R10 simultaneous enqueue and pop on the low FIFO
    enq(0, 34, 1, a, d);
    chk("R10 occ before", int'(occ_lo), 2);
    tx_ready = 1'b1;
    enq(1, 35, 2, a, d);
    tx_ready = 1'b0;
    chk("R10 occ after", int'(occ_lo), 2);
    pop(mc, cls, idx, uph, upl);
    chk("R10 order", idx, 34);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule